// File: doc/BRIEF.md
# Two-Entry Conflict-Free FIFO

A two-entry first-in first-out queue built from a head slot and a tail slot. Each slot has its own valid flag. Reads always come from the head slot and new data always lands in the tail slot. At the end of every cycle a compaction step moves a lone tail element into the head slot. So a queue holding one element always holds it in the head slot.

The status outputs and the head data come straight from registers. They are never affected by the enqueue or dequeue strobes of the same cycle. Enqueue and dequeue may be issued together whenever the queue is neither full nor empty, and neither sees the other's effect in that cycle. There is no combinational path between the enqueue side and the dequeue side.

Two kinds of request are ignored: an enqueue into a full queue and a dequeue from an empty queue. Either one sets a sticky error flag, which only reset clears.

Top module: `cf_fifo2`

## Requirements
- R1: After reset, not_empty_o=0, not_full_o=1 and err_o=0.
- R2: not_full_o, not_empty_o, first_o and err_o change only at a rising clock edge. Changing enq_i, deq_i or enq_data_i inside a cycle leaves them unchanged until that edge.
- R3: An enqueue while not_full_o=1 is accepted, and its data is returned later in arrival order.
- R4: A dequeue while not_empty_o=1 removes the oldest element. After the next edge, first_o shows the following element, or not_empty_o=0 if no element remains.
- R5: An enqueue into an empty queue gives not_empty_o=1 and first_o equal to the enqueued data at the very next edge. not_full_o=0 never occurs together with not_empty_o=0.
- R6: An enqueue and a dequeue issued together while exactly one element is held leave exactly one element. That element is the new data, and not_full_o=1 and not_empty_o=1 after the edge.
- R7: An enqueue while not_full_o=0 has no effect on the contents and sets err_o at the next edge.
- R8: A dequeue while not_empty_o=0 has no effect: the queue stays empty and err_o is set at the next edge.
- R9: Once set, err_o stays 1 until rst_ni is asserted (low). Reset returns it to 0.
- R10: An enqueue and a dequeue issued together while full drop the enqueue and perform the dequeue. Exactly one element, the younger stored one, remains, and err_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_i | input | 1 | Enqueue strobe |
| enq_data_i | input | DATA_W | Data to enqueue |
| deq_i | input | 1 | Dequeue strobe |
| not_full_o | output | 1 | Tail slot empty: an enqueue will be accepted |
| not_empty_o | output | 1 | Head slot valid |
| first_o | output | DATA_W | Head slot data |
| err_o | output | 1 | Sticky illegal-request flag |

## Verification
Every result of a strobe is due exactly one rising edge later: the flags, the head data and the error flag are all registers. This holds even when compaction moves data, because the move is folded into that same edge. The bench drives the strobes at the falling edge. It checks the outputs again 1 ns later to show they have not moved (R2). It then compares them at the next falling edge with a two-place queue model updated for the strobes just applied. Traffic sweeps every fill level against every strobe combination with random data. Directed steps cover reset and the stickiness of the error flag.

// File: rtl/cf_fifo2_pkg.sv
package cf_fifo2_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_DEQ  = 2'b01,
    OP_ENQ  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/cf_fifo2_slot.sv
module cf_fifo2_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_d_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= vld_d_i;
      if (load_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/cf_fifo2_next.sv
module cf_fifo2_next
  import cf_fifo2_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              enq_i,
  input  logic              deq_i,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              head_vld_i,
  input  logic              tail_vld_i,
  input  logic [DATA_W-1:0] tail_data_i,
  output logic              head_vld_d_o,
  output logic              head_load_o,
  output logic [DATA_W-1:0] head_data_d_o,
  output logic              tail_vld_d_o,
  output logic              tail_load_o,
  output logic [DATA_W-1:0] tail_data_d_o,
  output logic              illegal_o
);
  logic     enq_ok, deq_ok;
  fifo_op_e op;
  logic     head_mid, tail_mid, compact;
  logic [DATA_W-1:0] tail_mid_data;

  assign enq_ok = enq_i & ~tail_vld_i;
  assign deq_ok = deq_i & head_vld_i;
  assign op     = fifo_op_e'({enq_ok, deq_ok});
  assign illegal_o = (enq_i & tail_vld_i) | (deq_i & ~head_vld_i);

  // effects of the strobes, each on its own slot
  always_comb begin
    head_mid      = head_vld_i;
    tail_mid      = tail_vld_i;
    tail_mid_data = tail_data_i;
    unique case (op)
      OP_DEQ:  head_mid = 1'b0;
      OP_ENQ:  begin tail_mid = 1'b1; tail_mid_data = enq_data_i; end
      OP_BOTH: begin
        head_mid = 1'b0; tail_mid = 1'b1; tail_mid_data = enq_data_i;
      end
      default: ;
    endcase
  end

  // end-of-cycle compaction into the head slot
  assign compact       = tail_mid & ~head_mid;
  assign head_vld_d_o  = head_mid | compact;
  assign head_load_o   = compact;
  assign head_data_d_o = tail_mid_data;
  assign tail_vld_d_o  = tail_mid & ~compact;
  assign tail_load_o   = enq_ok;
  assign tail_data_d_o = enq_data_i;
endmodule

// File: rtl/cf_fifo2.sv
module cf_fifo2 #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              deq_i,
  output logic              not_full_o,
  output logic              not_empty_o,
  output logic [DATA_W-1:0] first_o,
  output logic              err_o
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]             vld_d, load, vld_q;
  logic [NSLOT-1:0][DATA_W-1:0] data_d, data_q;
  logic                         illegal;

  cf_fifo2_next #(.DATA_W(DATA_W)) u_next (
    .enq_i         (enq_i),
    .deq_i         (deq_i),
    .enq_data_i    (enq_data_i),
    .head_vld_i    (vld_q[0]),
    .tail_vld_i    (vld_q[1]),
    .tail_data_i   (data_q[1]),
    .head_vld_d_o  (vld_d[0]),
    .head_load_o   (load[0]),
    .head_data_d_o (data_d[0]),
    .tail_vld_d_o  (vld_d[1]),
    .tail_load_o   (load[1]),
    .tail_data_d_o (data_d[1]),
    .illegal_o     (illegal)
  );

  // slot 0 = head, slot 1 = tail
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cf_fifo2_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_d_i (vld_d[s]),
      .load_i  (load[s]),
      .data_i  (data_d[s]),
      .vld_o   (vld_q[s]),
      .data_o  (data_q[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else if (illegal) err_o <= 1'b1;
  end

  assign not_full_o  = ~vld_q[1];
  assign not_empty_o = vld_q[0];
  assign first_o     = data_q[0];
endmodule

// File: rtl/cf_fifo2_chk.sv
module cf_fifo2_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enq_i,
  input logic [DATA_W-1:0] enq_data_i,
  input logic              deq_i,
  input logic              not_full_o,
  input logic              not_empty_o,
  input logic [DATA_W-1:0] first_o,
  input logic              err_o
);
  // R5
  full_has_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_full_o |-> not_empty_o);
  // R5
  enq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && enq_i) |=> (not_empty_o && first_o == $past(enq_data_i)));
  // R6
  swap_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (not_empty_o && not_full_o && enq_i && deq_i)
      |=> (not_empty_o && not_full_o && first_o == $past(enq_data_i)));
  // R8
  deq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && deq_i && !enq_i) |=> (!not_empty_o && err_o));
  // R7
  enq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_full_o && enq_i && !deq_i) |=> (!not_full_o && err_o && $stable(first_o)));
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enq_i && !deq_i) |=> ($stable(not_full_o) && $stable(not_empty_o) && $stable(first_o)));
  // R10
  full_deq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_full_o && deq_i) |=> (not_full_o && not_empty_o));
endmodule

bind cf_fifo2 cf_fifo2_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enq_i       (enq_i),
  .enq_data_i  (enq_data_i),
  .deq_i       (deq_i),
  .not_full_o  (not_full_o),
  .not_empty_o (not_empty_o),
  .first_o     (first_o),
  .err_o       (err_o)
);

// File: tb/sim_cf_fifo2.sv
`timescale 1ns/1ps
module sim_cf_fifo2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq = 1'b0, deq = 1'b0;
  logic [DW-1:0] din = '0;
  logic          nf, ne, err;
  logic [DW-1:0] first;

  int checks = 0, errors = 0;
  bit done = 0;

  int            m_cnt = 0;
  logic [DW-1:0] m_q [2];
  bit            m_err = 0;

  always #5 clk = ~clk;

  cf_fifo2 #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enq_i(enq), .enq_data_i(din), .deq_i(deq),
    .not_full_o(nf), .not_empty_o(ne), .first_o(first), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    chk(ne == (m_cnt > 0), {tag, " not_empty"}, ne, m_cnt > 0);
    chk(nf == (m_cnt < 2), {tag, " not_full"}, nf, m_cnt < 2);
    chk(err == m_err, {tag, " err"}, err, m_err);
    if (m_cnt > 0) chk(first == m_q[0], {tag, " first"}, first, m_q[0]);
  endtask

  task automatic step(input bit e, input bit d, input logic [DW-1:0] v);
    string tag;
    logic snf, sne, serr;
    logic [DW-1:0] sfirst;
    snf = nf; sne = ne; serr = err; sfirst = first;
    enq = e; deq = d; din = v;
    #1;
    // R2: strobes must not reach the outputs before the edge
    chk(nf == snf && ne == sne && err == serr && first == sfirst,
        "R2 outputs moved mid-cycle", {nf, ne, err}, {snf, sne, serr});
    if (e && d && m_cnt == 2)      tag = "R10";
    else if (e && m_cnt == 2)      tag = "R7";
    else if (d && m_cnt == 0)      tag = "R8";
    else if (e && d && m_cnt == 1) tag = "R6";
    else if (e && m_cnt == 0)      tag = "R5";
    else if (d)                    tag = "R4";
    else if (e)                    tag = "R3";
    else                           tag = "R2";
    if (m_err) tag = {tag, "/R9"};
    if ((e && m_cnt == 2) || (d && m_cnt == 0)) m_err = 1;
    if (d && m_cnt > 0) begin m_q[0] = m_q[1]; m_cnt--; end
    if (e && m_cnt < 2 && !(d && m_cnt == 1 && 0)) begin
      if (!(e && d && tag.substr(0, 2) == "R10")) begin
        m_q[m_cnt] = v; m_cnt++;
      end
    end
    @(negedge clk);
    cmp_model(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_q[0] = '0; m_q[1] = '0;
    repeat (2) @(negedge clk);
    // R1
    cmp_model("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp_model("R1 after reset");

    // directed order: fill, swap, drain
    step(1, 0, 8'h11);
    step(1, 0, 8'h22);
    step(1, 0, 8'h33);   // R7 ignored
    step(1, 1, 8'h44);   // R10
    step(1, 1, 8'h55);   // R6
    step(0, 1, 8'h00);   // R4
    step(0, 1, 8'h00);   // R8
    repeat (3) step(0, 0, 8'h00);  // R9 held

    rst_n = 1'b0; #1;
    m_cnt = 0; m_err = 0;
    chk(err == 1'b0, "R9 reset clears err", err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_model("R1 second reset");

    // sweep: every fill level against every strobe pair, random data
    for (int r = 0; r < 400; r++) begin
      for (int lvl = 0; lvl < 3; lvl++) begin
        for (int op = 0; op < 4; op++) begin
          while (m_cnt > lvl) step(0, 1, 8'h00);
          while (m_cnt < lvl) step(1, 0, 8'($urandom));
          step(op[1], op[0], 8'($urandom));
        end
      end
    end
    for (int i = 0; i < 3000; i++) step(1'($urandom), 1'($urandom), 8'($urandom));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule